// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the control state machine of a multi-source clock generator. On every clock it samples a set of configuration bits: reference select, a 2-bit clock source select, PLL select, a low-power request, a debug-enabled indication and a stop request. From them it decides which of nine operating modes the generator should be in. It drives the enables for the FLL and the PLL and the select code for the final clock multiplexer. The oscillators, loops, dividers and the glitch-free multiplexer sit outside and follow these outputs.

A requested mode is only accepted when it is one step away from the current mode along a fixed set of allowed transitions. A request that decodes to no mode, or to a mode that is not a neighbour, is refused. The mode is then held and an error flag pulses. A stop request parks the generator in a Stop mode from anywhere and saves the mode it left. Releasing stop resumes the saved mode, unless reset arrived while stopped.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: The mode code `mode` uses these values: FEI=0, FBI=1, FEE=2, FBE=3, PBE=4, PEE=5, BLPI=6, BLPE=7, STOP=8.
- R2: While `rst` is high on a clock edge, the next cycle shows `mode`=FEI, `fll_en`=1, `pll_en`=0, `clk_sel`=00 and `err`=0. This holds even when `stop_req` is high.
- R3: With `ref_int`=1 and `src_sel`=00 and `pll_sel`=0, the request is FEI. With `ref_int`=1 and `src_sel`=01, the request is BLPI when `lowpwr`=1 and `dbg_en`=0, and FBI otherwise.
- R4: With `ref_int`=0 and `src_sel`=00, the request is FEE when `pll_sel`=0 and PEE when `pll_sel`=1. With `ref_int`=0 and `src_sel`=10, the request is BLPE when `lowpwr`=1 and `dbg_en`=0. Otherwise it is FBE when `pll_sel`=0 and PBE when `pll_sel`=1.
- R5: In BLPE, clearing `lowpwr` or setting `dbg_en` moves the mode to FBE when `pll_sel`=0 and to PBE when `pll_sel`=1.
- R6: `mode` is registered. It takes its new value one clock after the edge at which the qualifying inputs are sampled.
- R7: Only these transitions are allowed, in either direction: FEI-FBI, FEI-FEE, FBI-BLPI, FBI-FBE, FEE-FBE, FBE-BLPE, FBE-PBE, PBE-PEE and PBE-BLPE. A request for any other mode leaves `mode` unchanged.
- R8: `stop_req`=1 moves any mode to STOP and saves the mode it left. While in STOP, the configuration bits are ignored. On the first edge with `stop_req`=0, the saved mode returns. If `rst` was high during STOP, the mode that returns is FEI.
- R9: A request is rejected when it names a non-neighbour mode or decodes to no mode. The undecodable cases are `src_sel`=11, `ref_int`=1 with `src_sel`=10, `ref_int`=1 with `src_sel`=00 and `pll_sel`=1, and `ref_int`=0 with `src_sel`=01. A rejection holds the mode. `err` is high for exactly one cycle after the first edge of a run of rejected samples.
- R10: `fll_en` is 1 in FEI, FEE, FBI and FBE. `pll_en` is 1 in PBE and PEE. Both are 0 in BLPI, BLPE and STOP.
- R11: `clk_sel` is 00 (FLL output) in FEI, FEE and STOP, 01 (internal reference) in FBI and BLPI, 10 (external reference) in FBE, PBE and BLPE, and 11 (PLL output) in PEE. It is registered together with `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_int | input | 1 | Reference select, 1 = internal reference |
| src_sel | input | 2 | Clock source select |
| pll_sel | input | 1 | PLL select |
| lowpwr | input | 1 | Low-power request |
| dbg_en | input | 1 | Debug enabled |
| stop_req | input | 1 | Stop request |
| mode | output | 4 | Current mode code |
| fll_en | output | 1 | FLL enable |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 2 | Final clock mux select |
| err | output | 1 | One-cycle pulse on a rejected request |

## Verification
On every cycle, the assertions check the following: reset forces FEI, stop always wins over other requests, any step between two working modes is an allowed neighbour pair, the enables agree with the mode, and the error flag never lasts longer than one cycle while the mode stays put. The bench scenarios cover what depends on history or exact decoding. This includes the mode that returns after stop, the effect of reset during stop, the path out of BLPE for each PLL select value, the list of undecodable bit patterns, and the mux select value in each mode.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;
  localparam int MODE_W = 4;
  localparam int SRC_W  = 2;
  localparam int CSEL_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_FEI  = 4'd0,
    M_FBI  = 4'd1,
    M_FEE  = 4'd2,
    M_FBE  = 4'd3,
    M_PBE  = 4'd4,
    M_PEE  = 4'd5,
    M_BLPI = 4'd6,
    M_BLPE = 4'd7,
    M_STOP = 4'd8
  } mode_t;

  localparam logic [CSEL_W-1:0] CS_FLL = 2'b00;
  localparam logic [CSEL_W-1:0] CS_INT = 2'b01;
  localparam logic [CSEL_W-1:0] CS_EXT = 2'b10;
  localparam logic [CSEL_W-1:0] CS_PLL = 2'b11;

  // one-directional edge list of the transition graph
  function automatic logic edge_one_way(mode_t a, mode_t b);
    logic r;
    r = 1'b0;
    case (a)
      M_FEI: r = (b == M_FBI) || (b == M_FEE);
      M_FBI: r = (b == M_BLPI) || (b == M_FBE);
      M_FEE: r = (b == M_FBE);
      M_FBE: r = (b == M_BLPE) || (b == M_PBE);
      M_PBE: r = (b == M_PEE) || (b == M_BLPE);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic modes_adjacent(mode_t a, mode_t b);
    return edge_one_way(a, b) || edge_one_way(b, a);
  endfunction
endpackage

// File: rtl/clkgen_req_decode.sv
module clkgen_req_decode
  import clkgen_mode_pkg::*;
(
  input  logic             ref_int,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             pll_sel,
  input  logic             lowpwr,
  input  logic             dbg_en,
  output mode_t            req_mode,
  output logic             req_ok
);
  logic lp_gate;
  assign lp_gate = lowpwr && !dbg_en;

  always_comb begin
    req_mode = M_FEI;
    req_ok   = 1'b0;
    case ({ref_int, src_sel})
      3'b1_00: begin
        req_mode = M_FEI;
        req_ok   = !pll_sel;
      end
      3'b1_01: begin
        req_mode = lp_gate ? M_BLPI : M_FBI;
        req_ok   = 1'b1;
      end
      3'b0_00: begin
        req_mode = pll_sel ? M_PEE : M_FEE;
        req_ok   = 1'b1;
      end
      3'b0_10: begin
        if (lp_gate)      req_mode = M_BLPE;
        else if (pll_sel) req_mode = M_PBE;
        else              req_mode = M_FBE;
        req_ok = 1'b1;
      end
      default: begin
        req_mode = M_FEI;
        req_ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/clkgen_step_check.sv
module clkgen_step_check
  import clkgen_mode_pkg::*;
(
  input  mode_t cur_mode,
  input  mode_t req_mode,
  input  logic  req_ok,
  output logic  accept
);
  logic same;
  logic nbr;
  assign same   = (cur_mode == req_mode);
  assign nbr    = modes_adjacent(cur_mode, req_mode);
  assign accept = req_ok && (same || nbr);
endmodule

// File: rtl/clkgen_out_reg.sv
module clkgen_out_reg
  import clkgen_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode_nxt,
  output logic              fll_en,
  output logic              pll_en,
  output logic [CSEL_W-1:0] clk_sel
);
  logic              fll_d;
  logic              pll_d;
  logic [CSEL_W-1:0] sel_d;

  always_comb begin
    fll_d = 1'b0;
    pll_d = 1'b0;
    sel_d = CS_FLL;
    case (mode_nxt)
      M_FEI:  begin fll_d = 1'b1; sel_d = CS_FLL; end
      M_FEE:  begin fll_d = 1'b1; sel_d = CS_FLL; end
      M_FBI:  begin fll_d = 1'b1; sel_d = CS_INT; end
      M_FBE:  begin fll_d = 1'b1; sel_d = CS_EXT; end
      M_PBE:  begin pll_d = 1'b1; sel_d = CS_EXT; end
      M_PEE:  begin pll_d = 1'b1; sel_d = CS_PLL; end
      M_BLPI: sel_d = CS_INT;
      M_BLPE: sel_d = CS_EXT;
      default: sel_d = CS_FLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fll_en  <= 1'b1;
      pll_en  <= 1'b0;
      clk_sel <= CS_FLL;
    end else begin
      fll_en  <= fll_d;
      pll_en  <= pll_d;
      clk_sel <= sel_d;
    end
  end
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_int,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic              pll_sel,
  input  logic              lowpwr,
  input  logic              dbg_en,
  input  logic              stop_req,
  output logic [MODE_W-1:0] mode,
  output logic              fll_en,
  output logic              pll_en,
  output logic [CSEL_W-1:0] clk_sel,
  output logic              err
);
  mode_t cur_q, saved_q, mode_nxt, saved_nxt, req_mode;
  logic  req_ok, accept, reject, reject_q;

  clkgen_req_decode u_dec (
    .ref_int (ref_int),
    .src_sel (src_sel),
    .pll_sel (pll_sel),
    .lowpwr  (lowpwr),
    .dbg_en  (dbg_en),
    .req_mode(req_mode),
    .req_ok  (req_ok)
  );

  clkgen_step_check u_step (
    .cur_mode(cur_q),
    .req_mode(req_mode),
    .req_ok  (req_ok),
    .accept  (accept)
  );

  always_comb begin
    mode_nxt  = cur_q;
    saved_nxt = saved_q;
    reject    = 1'b0;
    if (rst) begin
      mode_nxt  = M_FEI;
      saved_nxt = M_FEI;
    end else if (cur_q == M_STOP) begin
      if (!stop_req) mode_nxt = saved_q;
    end else if (stop_req) begin
      saved_nxt = cur_q;
      mode_nxt  = M_STOP;
    end else if (accept) begin
      mode_nxt = req_mode;
    end else begin
      reject = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= M_FEI;
      saved_q  <= M_FEI;
      reject_q <= 1'b0;
      err      <= 1'b0;
    end else begin
      cur_q    <= mode_nxt;
      saved_q  <= saved_nxt;
      reject_q <= reject;
      err      <= reject && !reject_q;
    end
  end

  clkgen_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .mode_nxt(mode_nxt),
    .fll_en  (fll_en),
    .pll_en  (pll_en),
    .clk_sel (clk_sel)
  );

  assign mode = cur_q;
endmodule

// File: rtl/clkgen_mode_checker.sv
module clkgen_mode_checker
  import clkgen_mode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SRC_W-1:0]  src_sel,
  input logic              stop_req,
  input logic [MODE_W-1:0] mode,
  input logic              fll_en,
  input logic              pll_en,
  input logic              err
);
  p_reset_fei_r2: assert property (@(posedge clk) rst |=> (mode == M_FEI && fll_en && !pll_en && !err));

  p_stop_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_req && mode != M_STOP) |=> (mode == M_STOP));

  p_step_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode != $past(mode) && mode != M_STOP && $past(mode) != M_STOP)
    |-> modes_adjacent(mode_t'(mode), mode_t'($past(mode))));

  p_fll_modes_r10: assert property (@(posedge clk) disable iff (rst)
    fll_en |-> (mode == M_FEI || mode == M_FEE || mode == M_FBI || mode == M_FBE));

  p_pll_modes_r10: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> (mode == M_PBE || mode == M_PEE));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(rst)) |-> $stable(mode));

  p_src11_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b11 && !stop_req && mode != M_STOP) |=> $stable(mode));
endmodule

bind clkgen_mode_ctrl clkgen_mode_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_sel (src_sel),
  .stop_req(stop_req),
  .mode    (mode),
  .fll_en  (fll_en),
  .pll_en  (pll_en),
  .err     (err)
);

// File: tb/test_clkgen_mode_ctrl.sv
module test_clkgen_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [3:0] FEI = 0, FBI = 1, FEE = 2, FBE = 3, PBE = 4,
                         PEE = 5, BLPI = 6, BLPE = 7, STOP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_int = 1'b1;
  logic [1:0] src_sel = 2'b00;
  logic       pll_sel = 1'b0;
  logic       lowpwr = 1'b0;
  logic       dbg_en = 1'b0;
  logic       stop_req = 1'b0;
  logic [3:0] mode;
  logic       fll_en, pll_en, err;
  logic [1:0] clk_sel;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_mode_ctrl i_clkgen_mode_ctrl (
    .clk(clk), .rst(rst), .ref_int(ref_int), .src_sel(src_sel),
    .pll_sel(pll_sel), .lowpwr(lowpwr), .dbg_en(dbg_en),
    .stop_req(stop_req), .mode(mode), .fll_en(fll_en),
    .pll_en(pll_en), .clk_sel(clk_sel), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one rising edge between)
  task automatic step(input logic r, input logic [1:0] s, input logic p,
                      input logic lp, input logic d, input logic st);
    @(negedge clk);
    ref_int = r; src_sel = s; pll_sel = p; lowpwr = lp; dbg_en = d; stop_req = st;
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic [3:0] m, input logic f,
                         input logic p, input logic [1:0] cs);
    chk({tag, " mode"}, mode, m);
    chk({tag, " fll_en (R10)"}, fll_en, f);
    chk({tag, " pll_en (R10)"}, pll_en, p);
    chk({tag, " clk_sel (R11)"}, clk_sel, cs);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_out("R2 reset", FEI, 1, 0, 2'b00);
    chk("R2 err", err, 0);
    rst = 1'b0;
    step(1, 2'b00, 0, 0, 0, 0);
    chk("R1 FEI code holds", mode, 0);
  endtask

  task automatic t_internal;
    // the request is sampled at the rising edge, so mode changes one cycle later (R6)
    @(negedge clk);
    src_sel = 2'b01;
    chk("R6 not yet changed", mode, FEI);
    @(negedge clk);
    chk_out("R3 FBI", FBI, 1, 0, 2'b01);
    step(1, 2'b01, 0, 1, 0, 0);
    chk_out("R3 BLPI", BLPI, 0, 0, 2'b01);
    step(1, 2'b01, 0, 1, 1, 0);
    chk_out("R3 dbg gives FBI", FBI, 1, 0, 2'b01);
    step(1, 2'b00, 0, 0, 0, 0);
    chk_out("R3 back to FEI", FEI, 1, 0, 2'b00);
  endtask

  task automatic t_external;
    step(0, 2'b00, 0, 0, 0, 0);
    chk_out("R4 FEE", FEE, 1, 0, 2'b00);
    step(0, 2'b10, 0, 0, 0, 0);
    chk_out("R4 FBE", FBE, 1, 0, 2'b10);
    step(0, 2'b10, 1, 0, 0, 0);
    chk_out("R4 PBE", PBE, 0, 1, 2'b10);
    step(0, 2'b00, 1, 0, 0, 0);
    chk_out("R4 PEE", PEE, 0, 1, 2'b11);
    step(0, 2'b10, 1, 0, 0, 0);
    chk_out("R7 PEE to PBE", PBE, 0, 1, 2'b10);
    step(0, 2'b10, 1, 1, 0, 0);
    chk_out("R4 BLPE", BLPE, 0, 0, 2'b10);
    step(0, 2'b10, 1, 0, 0, 0);
    chk_out("R5 lowpwr clear pll=1", PBE, 0, 1, 2'b10);
    step(0, 2'b10, 1, 1, 0, 0);
    chk("R5 BLPE again", mode, BLPE);
    step(0, 2'b10, 0, 1, 1, 0);
    chk_out("R5 dbg set pll=0", FBE, 1, 0, 2'b10);
  endtask

  task automatic t_reject;
    // in FBE: request PEE (not a neighbour)
    step(0, 2'b00, 1, 0, 0, 0);
    chk("R7 non-neighbour held", mode, FBE);
    chk("R9 err pulse", err, 1);
    @(negedge clk);
    chk("R9 err one cycle", err, 0);
    chk("R7 still held", mode, FBE);
    step(0, 2'b10, 0, 0, 0, 0);
    chk("R9 no err on valid", err, 0);
    step(0, 2'b11, 0, 0, 0, 0);
    chk("R9 src 11 held", mode, FBE);
    chk("R9 src 11 err", err, 1);
    step(0, 2'b10, 0, 0, 0, 0);
    step(1, 2'b10, 0, 0, 0, 0);
    chk("R9 int ref with src 10", err, 1);
    step(0, 2'b10, 0, 0, 0, 0);
    step(0, 2'b01, 0, 0, 0, 0);
    chk("R9 ext ref with src 01", err, 1);
    chk("R9 mode held", mode, FBE);
    step(0, 2'b10, 0, 0, 0, 0);
  endtask

  task automatic t_stop_resume;
    step(0, 2'b10, 0, 0, 0, 1);
    chk_out("R8 stop entry", STOP, 0, 0, 2'b00);
    step(1, 2'b01, 0, 0, 0, 1);
    chk("R8 config ignored in stop", mode, STOP);
    chk("R8 no err in stop", err, 0);
    step(1, 2'b01, 0, 0, 0, 0);
    chk_out("R8 resume saved", FBE, 1, 0, 2'b10);
    step(0, 2'b10, 0, 0, 0, 0);
    chk("R8 stays after resume", mode, FBE);
  endtask

  task automatic t_stop_reset;
    step(0, 2'b10, 0, 0, 0, 1);
    chk("R8 stopped", mode, STOP);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 reset wins over stop", mode, FEI);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 stop after reset", mode, STOP);
    step(1, 2'b00, 0, 0, 0, 0);
    chk_out("R8 reset in stop gives FEI", FEI, 1, 0, 2'b00);
    step(1, 2'b00, 1, 0, 0, 0);
    chk("R9 int ref with pll", err, 1);
    chk("R9 held FEI", mode, FEI);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_internal();
        t_external();
        t_reject();
        t_stop_resume();
        t_stop_reset();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_errs++;
          $display("FAIL watchdog: actual=hung expected=done");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule